// File: doc/BRIEF.md
# Keyboard and Display Scan Timing Generator

This block supplies the scan timing used by a keyboard and display controller. A programmable prescaler divides the system clock by a 5-bit value N to produce an internal base tick. A second counter stage groups a fixed number of base ticks into one scan step. At each step a 4-bit scan index advances. The index drives four scan lines in one of two encodings.

In binary mode the lines carry the index itself, active high, over all 16 positions. An external decoder can fan these out to 16 display digits. Only the lower half of that range is valid for key sensing. In decoded mode the two low index bits select one of four lines, and the selected line is pulled low. This drives a four-digit display or a four-row key matrix directly.

A one-clock strobe marks each step, so that the keyboard and display logic know when a new scan position begins. All outputs come straight from registers, so they do not change between strobes.

Top module: `scan_timing_gen`

## Requirements
- R1: The effective prescale ratio is `div_n` when `div_n` is 2 or more. Values 0 and 1 are both treated as 2.
- R2: Once the configuration is stable, consecutive `step_stb` pulses are exactly (effective ratio × STEP_TICKS) clock cycles apart. STEP_TICKS defaults to 4.
- R3: `step_stb` is high for exactly one clock cycle per step.
- R4: In the cycle where `step_stb` is high, `scan_idx` already shows the new index, which is the previous index plus one modulo 16 (15 is followed by 0).
- R5: Between strobes, `scan_idx` and `scan_lines` hold their values.
- R6: With `mode_sel` = 0 (binary), `scan_lines` equals `scan_idx`, active high.
- R7: With `mode_sel` = 1 (decoded), `scan_lines` is 4'b1111 with only bit `scan_idx[1:0]` cleared.
- R8: `kbd_valid` is 1 in binary mode exactly when `scan_idx` < 8. In decoded mode it is always 1.
- R9: While `rst_n` is low, `scan_idx` is 0, `step_stb` is 0 and `scan_lines` is 4'b0000. A few cycles after release, `scan_lines` shows the encoding of index 0 before the first strobe.
- R10: A change of `mode_sel` re-encodes `scan_lines` on the next clock edge and leaves `scan_idx` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| div_n | input | 5 | Prescale ratio N (0 and 1 mean 2) |
| mode_sel | input | 1 | 0 = binary active-high lines, 1 = decoded active-low one-of-four |
| scan_lines | output | 4 | Registered scan line drive |
| scan_idx | output | 4 | Current scan index |
| step_stb | output | 1 | One-cycle pulse at each index advance |
| kbd_valid | output | 1 | Current position is usable for key sensing |

## Verification
A prescaler that miscounts shows up as a wrong spacing between strobes, visible from the second strobe after any change in configuration. An index register that skips, sticks or wraps at the wrong value is seen at the very next strobe, as a step that is not +1. A wrong encoder register shows up on the lines within one clock of a step or a mode change, because the lines are compared against the index on every cycle between strobes.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int SCAN_LINES = 4;
  localparam int IDX_W      = 4;

  typedef enum logic {
    SCAN_BINARY  = 1'b0,
    SCAN_DECODED = 1'b1
  } scan_mode_e;
endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/scan_tick_chain.sv
module scan_tick_chain #(
  parameter int DIV_W      = 5,
  parameter int STEP_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_n,
  output logic             adv_o,
  output logic             stb_o
);
  localparam int STEP_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_TICKS - 1);
  localparam logic [DIV_W-1:0]  DIV_MIN   = DIV_W'(2);

  logic [DIV_W-1:0]  n_eff;
  logic [DIV_W-1:0]  n_last;
  logic [DIV_W-1:0]  pre_q, pre_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              tick;
  logic              last_tick;
  logic              adv;
  logic              stb_q, stb_d;

  // prescaler: ratios below two are clamped to two
  always_comb begin
    n_eff  = (div_n < DIV_MIN) ? DIV_MIN : div_n;
    n_last = n_eff - DIV_W'(1);
    tick   = (pre_q >= n_last);
    pre_d  = tick ? '0 : pre_q + DIV_W'(1);
  end

  // step stage: STEP_TICKS base ticks per scan position
  always_comb begin
    last_tick = (step_q == STEP_LAST);
    adv       = tick && last_tick;
    step_d    = step_q;
    if (tick) step_d = last_tick ? '0 : step_q + STEP_W'(1);
    stb_d     = adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    step_q <= '0;
    else if (tick) step_q <= step_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_d;
  end

  assign adv_o = adv;
  assign stb_o = stb_q;

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q); // R3

  AST_STB_FOLLOWS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> stb_q); // R2
endmodule

// File: rtl/scan_index_ctr.sv
module scan_index_ctr
  import scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] idx_next_o
);
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = adv ? idx_q + IDX_W'(1) : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= '0;
    else if (adv) idx_q <= idx_d;
  end

  assign idx_o      = idx_q;
  assign idx_next_o = idx_d;

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (idx_q == $past(idx_q) + IDX_W'(1))); // R4

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(idx_q)); // R5
endmodule

// File: rtl/scan_line_enc.sv
module scan_line_enc
  import scan_pkg::*;
#(
  parameter int KEY_ROWS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      idx_next,
  input  logic                  mode_sel,
  output logic [SCAN_LINES-1:0] lines_o,
  output logic                  kbd_valid_o
);
  localparam logic [IDX_W:0] KEY_LIMIT = (IDX_W+1)'(KEY_ROWS);

  scan_mode_e            mode;
  logic [SCAN_LINES-1:0] bin_lines;
  logic [SCAN_LINES-1:0] dec_lines;
  logic [SCAN_LINES-1:0] lines_q, lines_d;
  logic                  kbd_q, kbd_d;

  assign mode = scan_mode_e'(mode_sel);

  genvar g;
  generate
    for (g = 0; g < SCAN_LINES; g++) begin : g_line
      assign bin_lines[g] = idx_next[g];
      assign dec_lines[g] = (idx_next[1:0] != 2'(g));
    end
  endgenerate

  always_comb begin
    lines_d = (mode == SCAN_DECODED) ? dec_lines : bin_lines;
    kbd_d   = (mode == SCAN_DECODED) ? 1'b1 : ({1'b0, idx_next} < KEY_LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= '0;
      kbd_q   <= 1'b0;
    end else begin
      lines_q <= lines_d;
      kbd_q   <= kbd_d;
    end
  end

  assign lines_o     = lines_q;
  assign kbd_valid_o = kbd_q;

  AST_DEC_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel |=> ($countones(~lines_q) == 1)); // R7

  AST_DEC_KBD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel |=> kbd_q); // R8
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import scan_pkg::*;
#(
  parameter int DIV_W      = 5,
  parameter int STEP_TICKS = 4,
  parameter int KEY_ROWS   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIV_W-1:0]      div_n,
  input  logic                  mode_sel,
  output logic [SCAN_LINES-1:0] scan_lines,
  output logic [IDX_W-1:0]      scan_idx,
  output logic                  step_stb,
  output logic                  kbd_valid
);
  logic             srst_n;
  logic             adv;
  logic [IDX_W-1:0] idx_next;

  scan_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  scan_tick_chain #(.DIV_W(DIV_W), .STEP_TICKS(STEP_TICKS)) u_chain (
    .clk   (clk),
    .rst_n (srst_n),
    .div_n (div_n),
    .adv_o (adv),
    .stb_o (step_stb)
  );

  scan_index_ctr u_idx (
    .clk        (clk),
    .rst_n      (srst_n),
    .adv        (adv),
    .idx_o      (scan_idx),
    .idx_next_o (idx_next)
  );

  scan_line_enc #(.KEY_ROWS(KEY_ROWS)) u_enc (
    .clk         (clk),
    .rst_n       (srst_n),
    .idx_next    (idx_next),
    .mode_sel    (mode_sel),
    .lines_o     (scan_lines),
    .kbd_valid_o (kbd_valid)
  );

  AST_STB_WITH_STEP: assert property (@(posedge clk) disable iff (!srst_n)
    step_stb |-> (scan_idx == $past(scan_idx) + 4'd1)); // R4
endmodule

// File: tb/sim_scan_timing_gen.sv
module sim_scan_timing_gen;
  localparam int STEP_TICKS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] div_n = 5'd2;
  logic       mode_sel = 1'b0;
  logic [3:0] scan_lines;
  logic [3:0] scan_idx;
  logic       step_stb;
  logic       kbd_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  scan_timing_gen #(.DIV_W(5), .STEP_TICKS(STEP_TICKS), .KEY_ROWS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .div_n(div_n), .mode_sel(mode_sel),
    .scan_lines(scan_lines), .scan_idx(scan_idx),
    .step_stb(step_stb), .kbd_valid(kbd_valid)
  );

  // vector: {div_n, mode_sel, steps to observe}
  localparam logic [13:0] VEC [7] = '{
    {5'd0,  1'b0, 8'd18},
    {5'd1,  1'b1, 8'd6},
    {5'd2,  1'b0, 8'd4},
    {5'd5,  1'b1, 8'd6},
    {5'd31, 1'b0, 8'd3},
    {5'd7,  1'b0, 8'd17},
    {5'd3,  1'b1, 8'd5}
  };

  function automatic logic [3:0] enc(input logic [3:0] idx, input logic m);
    enc = m ? ~(4'b0001 << idx[1:0]) : idx;
  endfunction

  function automatic int eff(input logic [4:0] d);
    eff = (d < 5'd2) ? 2 : int'(d);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_stb();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (step_stb) return;
    end
    chk(1'b0, "R2 strobe missing", 0, 1);
  endtask

  task automatic run_vec(input logic [4:0] d, input logic m, input int steps);
    logic [3:0] prev;
    int cyc;
    bit hold_ok;
    @(negedge clk);
    div_n = d;
    mode_sel = m;
    wait_stb();
    prev = scan_idx;
    for (int s = 0; s < steps; s++) begin
      cyc = 0;
      hold_ok = 1'b1;
      do begin
        @(negedge clk);
        cyc++;
        if (!step_stb) begin
          if (scan_idx != prev || scan_lines != enc(prev, m)) hold_ok = 1'b0;
        end
        if (cyc == 1 && step_stb) hold_ok = 1'b0;
      end while (!step_stb && cyc < 2000);
      chk(hold_ok, "R3/R5 hold between strobes", scan_lines, enc(prev, m));
      chk(cyc == eff(d) * STEP_TICKS, "R1/R2 strobe period", cyc, eff(d) * STEP_TICKS);
      chk(scan_idx == prev + 4'd1, "R4 index step", scan_idx, prev + 4'd1);
      if (m) chk(scan_lines == enc(scan_idx, m), "R7 decoded lines", scan_lines, enc(scan_idx, m));
      else   chk(scan_lines == enc(scan_idx, m), "R6 binary lines", scan_lines, enc(scan_idx, m));
      chk(kbd_valid == (m || scan_idx < 4'd8), "R8 key valid", kbd_valid, m || scan_idx < 4'd8);
      prev = scan_idx;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] held;
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(scan_idx == 4'd0, "R9 reset index", scan_idx, 0);
    chk(step_stb == 1'b0, "R9 reset strobe", step_stb, 0);
    chk(scan_lines == 4'b0000, "R9 reset lines", scan_lines, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(scan_lines == enc(4'd0, 1'b0) && scan_idx == 4'd0, "R9 post-reset index 0", scan_lines, 0);

    foreach (VEC[i]) run_vec(VEC[i][13:9], VEC[i][8], int'(VEC[i][7:0]));

    // R10: mode switch mid-hold at a slow ratio
    @(negedge clk);
    div_n = 5'd31;
    mode_sel = 1'b0;
    wait_stb();
    repeat (3) @(negedge clk);
    held = scan_idx;
    mode_sel = 1'b1;
    @(negedge clk);
    chk(scan_lines == enc(held, 1'b1), "R10 mode switch lines", scan_lines, enc(held, 1'b1));
    chk(scan_idx == held, "R10 index kept", scan_idx, held);
    mode_sel = 1'b0;
    @(negedge clk);
    chk(scan_lines == enc(held, 1'b0), "R10 switch back lines", scan_lines, enc(held, 1'b0));

    // R9: reset in the middle of a run, decoded mode after release
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(scan_idx == 4'd0 && scan_lines == 4'b0000, "R9 async reset", scan_lines, 0);
    mode_sel = 1'b1;
    div_n = 5'd2;
    @(negedge clk);
    chk(step_stb == 1'b0, "R9 strobe low in reset", step_stb, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(scan_lines == 4'b1110 && scan_idx == 4'd0, "R9 decoded index 0 after reset", scan_lines, 14);
    chk(kbd_valid == 1'b1, "R8 decoded key valid", kbd_valid, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule